// File: doc/BRIEF.md
# Post-Minus-Pre Pulse Discriminator

This block finds pulses in one channel of a photomultiplier digitiser running at one sample per clock (64 MHz in the target system). On every sample it subtracts the sample taken a programmable number of steps earlier from the newest one. It fires when that rising difference is strictly larger than the channel's threshold. Because it responds to the slope and not to the level, a slow drift or a flat baseline never fires it, however high it sits.

When it fires, the block emits a one-cycle strobe for the trigger sums and opens a capture window. The window holds a programmable number of samples before the firing sample, the firing sample itself, and a programmable number after it. During the window it keeps the largest sample seen and counts how many consecutive samples stay above threshold. The samples are packed two to a 33-bit word, and a header word carrying the channel number, a sample timestamp, the width and the peak goes in front of them. All other samples are discarded.

Events go into an on-chip FIFO. An event becomes readable only once its header is complete. If the FIFO cannot hold the whole event at the moment of firing, the event is discarded and a drop counter advances.

Top module: `pmp_discriminator`

## Requirements
- R1: After reset, `rd_valid`, `disc_fire` and `drop_count` are all zero.
- R2: Let the newest captured sample minus the sample `cfg_lag` places before it be the difference. The channel fires only when this difference is strictly greater than `cfg_thr`; a difference equal to the threshold does not fire. A sample presented before clock edge k that fires raises `disc_fire` for exactly one cycle, from edge k+1 to edge k+2.
- R3: `cfg_lag` (1 to 7) selects how many samples back the subtracted sample lies, so the same input edge may fire at one lag and stay silent at another.
- R4: An input that rises by less than the threshold within the lag, or stays flat, never fires, whatever its absolute level.
- R5: A captured event holds `cfg_pre` samples before the firing sample, the firing sample, and `cfg_post` samples after it, in arrival order. Data words carry bit 32 = 0, the earlier sample of each pair in bits 15:0 and the later one in bits 31:16. When the count is odd, the last word has zero in bits 31:16.
- R6: Each event begins with a header word with bit 32 = 1. Bits 31:28 hold the channel number parameter. Bits 27:20 hold the low 8 bits of the firing sample's index, counting samples captured since reset with the first one as 1. Bits 19:16 hold the width and bits 15:0 the peak.
- R7: The peak is the largest sample in the event window. The width is the number of consecutive samples, starting at the firing sample and checked up to `cfg_post`+1 samples, whose difference exceeds the threshold.
- R8: From the firing cycle until the header is written (window length plus one cycle), no new firing happens and no second event is started.
- R9: No word of an event is readable before its header is stored; the whole event then becomes readable at once and is popped one word per cycle with `rd_en` while `rd_valid` is high.
- R10: If free FIFO space at firing is smaller than one header plus the event's data words, nothing of that event is stored, `drop_count` increments by one, and `disc_fire` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | SAMPLE_W | Digitised pulse height |
| cfg_thr | input | SAMPLE_W | Firing threshold for the difference |
| cfg_lag | input | 3 | Distance in samples between the two subtracted samples |
| cfg_pre | input | 3 | Samples kept before the firing sample |
| cfg_post | input | 3 | Samples kept after the firing sample |
| disc_fire | output | 1 | One-cycle firing strobe for trigger sums |
| rd_en | input | 1 | Pop the word on rd_data |
| rd_valid | output | 1 | A committed word is available |
| rd_data | output | 2*SAMPLE_W+1 | Oldest committed FIFO word |
| drop_count | output | DROP_W | Events discarded for lack of room |

## Verification
The embedded assertions watch, on every cycle, that the strobe never lasts two cycles, that a strobe always finds a capture window open, that the drop counter only moves together with a strobe, and that no commit can push occupancy past the FIFO depth. They also check that the first word to appear in an empty FIFO is a header and that a finished window never reports a width outside its legal range. Only the directed scenarios can show the arithmetic side: the strict threshold boundary, the effect of the lag on the same edge, the window contents and pair packing, the timestamp, peak and width values, the moment an event becomes readable, and that a dropped event leaves no trace in the FIFO.

// File: rtl/pmp_pkg.sv
// Shared constants and types for the post-minus-pre discriminator.
// Assumes the header layout: marker, channel, timestamp, width, peak.
package pmp_pkg;
    localparam int CH_W  = 4;   // channel number field in the header
    localparam int WID_W = 4;   // width field; holds up to 15 samples

    typedef enum logic [1:0] {
        WIN_IDLE,   // armed, waiting for a firing
        WIN_RUN,    // collecting window samples
        WIN_HDR     // writing the header and committing the event
    } win_state_t;
endpackage

// File: rtl/pmp_history.sv
// Sample history line for one channel.
// Holds the last DEPTH samples; index 0 is the newest captured one.
// Provides the sample selected by the lag (for the difference) and the
// sample selected by the pre count (the window tap).
// Assumes DEPTH is a power of two and both selects stay below DEPTH.
module pmp_history #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 8,
    parameter int SEL_W    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [SEL_W-1:0]    lag_sel,
    input  logic [SEL_W-1:0]    tap_sel,
    output logic [SAMPLE_W-1:0] newest,
    output logic [SAMPLE_W-1:0] lagged,
    output logic [SAMPLE_W-1:0] tapped
);
    logic [SAMPLE_W-1:0] line_q [DEPTH];
    logic [SEL_W-1:0]    lag_eff;

    // Shift every sample one place older on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else begin
            line_q[0] <= sample_in;
            for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
        end
    end

    // A lag of zero is meaningless; treat it as one.
    always_comb lag_eff = (lag_sel == '0) ? SEL_W'(1) : lag_sel;

    assign newest = line_q[0];
    assign lagged = line_q[lag_eff];
    assign tapped = line_q[tap_sel];
endmodule

// File: rtl/pmp_trigger.sv
// Post-minus-pre comparator and firing strobe.
// Computes newest minus lagged sample as a signed value and compares it
// strictly against the threshold. Firing is allowed only while the
// capture side reports idle; the strobe is registered.
module pmp_trigger #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] newest,
    input  logic [SAMPLE_W-1:0] lagged,
    input  logic [SAMPLE_W-1:0] thr,
    input  logic                idle,
    output logic                over,
    output logic                fire_now,
    output logic                disc_fire
);
    logic signed [SAMPLE_W:0] diff;

    // Signed rising difference and strict threshold test.
    always_comb begin
        diff     = $signed({1'b0, newest}) - $signed({1'b0, lagged});
        over     = diff > $signed({1'b0, thr});
        fire_now = over && idle;
    end

    // Register the strobe for the trigger sums.
    always_ff @(posedge clk) begin
        if (!rst_n) disc_fire <= 1'b0;
        else        disc_fire <= fire_now;
    end

    // R2: the strobe never lasts longer than one cycle.
    assert_fire_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disc_fire |=> !disc_fire);
endmodule

// File: rtl/pmp_capture.sv
// Window sequencer, peak/width tracker and word packer.
// On a firing it reserves a header slot at the FIFO's committed pointer.
// If the whole event does not fit, it marks the event as dropped.
// It streams packed sample pairs behind the slot, writes the header one
// cycle after the last sample, and commits the event.
// Assumes cfg_pre and cfg_post stay constant while a window is open.
module pmp_capture
    import pmp_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SEL_W    = 3,
    parameter int AW       = 10,
    parameter int CHANNEL  = 0,
    parameter int DROP_W   = 16,
    parameter int WORD_W   = 2 * SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire_now,
    input  logic                over,
    input  logic [SAMPLE_W-1:0] tap,
    input  logic [SEL_W-1:0]    cfg_pre,
    input  logic [SEL_W-1:0]    cfg_post,
    input  logic [AW:0]         wr_base,
    input  logic [AW:0]         free_words,
    output logic                idle,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output logic [WORD_W-1:0]   wr_data,
    output logic                commit,
    output logic [AW:0]         commit_ptr,
    output logic [DROP_W-1:0]   drop_count
);
    localparam int LEN_W = SEL_W + 2;
    localparam int TS_W  = 2 * SAMPLE_W - CH_W - WID_W - SAMPLE_W;

    win_state_t          state;
    logic [LEN_W-1:0]    pos_r, nw_r;
    logic [AW:0]         base_r;
    logic                keep_r, run_r;
    logic [SAMPLE_W-1:0] peak_r, lo_r;
    logic [WID_W-1:0]    width_r;
    logic [TS_W-1:0]     ts_cnt, ts_r;

    logic [LEN_W-1:0]    wlen, nwords, j;
    logic [AW:0]         need, base, addr_full;
    logic                room_ok, step, keep, last, data_wr, hdr_wr;

    // Window length, word count and room test for a new event.
    always_comb begin
        wlen    = LEN_W'(cfg_pre) + LEN_W'(cfg_post) + LEN_W'(1);
        nwords  = (wlen + LEN_W'(1)) >> 1;
        need    = (AW+1)'(nwords) + (AW+1)'(1);
        room_ok = free_words >= need;
    end

    // Per-cycle window position, target slot and write request.
    always_comb begin
        step      = fire_now || (state == WIN_RUN);
        j         = (state == WIN_RUN) ? pos_r : '0;
        base      = (state == WIN_RUN) ? base_r : wr_base;
        keep      = (state == WIN_RUN) ? keep_r : room_ok;
        last      = (j == wlen - LEN_W'(1));
        addr_full = base + (AW+1)'(1) + (AW+1)'(j >> 1);
        data_wr   = step && keep && (j[0] || last);
        hdr_wr    = (state == WIN_HDR) && keep_r;
        wr_en     = data_wr || hdr_wr;
        if (hdr_wr) begin
            wr_addr = base_r[AW-1:0];
            wr_data = {1'b1, CH_W'(CHANNEL), ts_r, width_r, peak_r};
        end else begin
            wr_addr = addr_full[AW-1:0];
            wr_data = j[0] ? {1'b0, tap, lo_r} : {1'b0, {SAMPLE_W{1'b0}}, tap};
        end
        commit     = hdr_wr;
        commit_ptr = base_r + (AW+1)'(1) + (AW+1)'(nw_r);
        idle       = (state == WIN_IDLE);
    end

    // Sequence the window and track timestamp, peak and width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WIN_IDLE;
            pos_r      <= '0;
            nw_r       <= '0;
            base_r     <= '0;
            keep_r     <= 1'b0;
            run_r      <= 1'b0;
            peak_r     <= '0;
            lo_r       <= '0;
            width_r    <= '0;
            ts_cnt     <= '0;
            ts_r       <= '0;
            drop_count <= '0;
        end else begin
            ts_cnt <= ts_cnt + TS_W'(1);
            unique case (state)
                WIN_IDLE: if (fire_now) begin
                    base_r  <= wr_base;
                    keep_r  <= room_ok;
                    nw_r    <= nwords;
                    ts_r    <= ts_cnt;
                    peak_r  <= tap;
                    lo_r    <= tap;
                    width_r <= WID_W'(1);
                    run_r   <= 1'b1;
                    pos_r   <= LEN_W'(1);
                    if (!room_ok) drop_count <= drop_count + DROP_W'(1);
                    state   <= last ? WIN_HDR : WIN_RUN;
                end
                WIN_RUN: begin
                    if (tap > peak_r) peak_r <= tap;
                    lo_r  <= tap;
                    pos_r <= pos_r + LEN_W'(1);
                    if (pos_r <= LEN_W'(cfg_post) && run_r) begin
                        if (over) width_r <= width_r + WID_W'(1);
                        else      run_r   <= 1'b0;
                    end
                    if (last) state <= WIN_HDR;
                end
                WIN_HDR: state <= WIN_IDLE;
                default: state <= WIN_IDLE;
            endcase
        end
    end

    // R7: a finished window reports a width between one and post+1.
    assert_width_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WIN_HDR) |-> (width_r != '0 && width_r <= WID_W'(cfg_post) + WID_W'(1)));
endmodule

// File: rtl/pmp_fifo.sv
// Event FIFO with a committed write pointer.
// The capture side writes words at any slot beyond the committed pointer;
// they become visible to the reader only when the event is committed.
// Read data is the word at the read pointer (show-ahead).
// Assumes DEPTH is a power of two.
module pmp_fifo #(
    parameter int WORD_W = 33,
    parameter int DEPTH  = 1024,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              commit,
    input  logic [AW:0]       commit_ptr,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [AW:0]       wr_base,
    output logic [AW:0]       free_words
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW:0]       wptr, rptr, count;

    // Store words at the slot chosen by the capture side.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Advance the committed pointer on commit and the read pointer on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (commit)            wptr <= commit_ptr;
            if (rd_en && rd_valid) rptr <= rptr + (AW+1)'(1);
        end
    end

    // Occupancy, free space and show-ahead read port.
    always_comb begin
        count      = wptr - rptr;
        free_words = (AW+1)'(DEPTH) - count;
        rd_valid   = (count != '0);
        rd_data    = mem[rptr[AW-1:0]];
        wr_base    = wptr;
    end

    // R10: a commit never makes occupancy exceed the depth.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((commit_ptr - rptr) <= (AW+1)'(DEPTH)));

    // R6: the first word readable from an empty FIFO is a header.
    assert_header_leads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> rd_data[WORD_W-1]);
endmodule

// File: rtl/pmp_discriminator.sv
// Post-minus-pre pulse discriminator for one digitiser channel.
// Fires on a rising difference over a programmable lag, captures a window
// of samples with a header carrying peak and width, and buffers whole
// events in an on-chip FIFO, dropping events that do not fit.
// Assumes one sample per clock and configuration held steady while busy.
module pmp_discriminator #(
    parameter int SAMPLE_W   = 16,
    parameter int HIST_DEPTH = 8,
    parameter int FIFO_DEPTH = 1024,
    parameter int CHANNEL    = 0,
    parameter int DROP_W     = 16,
    localparam int SEL_W     = $clog2(HIST_DEPTH),
    localparam int WORD_W    = 2 * SAMPLE_W + 1,
    localparam int AW        = $clog2(FIFO_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [SAMPLE_W-1:0] cfg_thr,
    input  logic [SEL_W-1:0]    cfg_lag,
    input  logic [SEL_W-1:0]    cfg_pre,
    input  logic [SEL_W-1:0]    cfg_post,
    output logic                disc_fire,
    input  logic                rd_en,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    output logic [DROP_W-1:0]   drop_count
);
    logic [SAMPLE_W-1:0] newest, lagged, tapped;
    logic                over, fire_now, cap_idle;
    logic                wr_en, commit;
    logic [AW-1:0]       wr_addr;
    logic [WORD_W-1:0]   wr_data;
    logic [AW:0]         commit_ptr, wr_base, free_words;

    pmp_history #(.SAMPLE_W(SAMPLE_W), .DEPTH(HIST_DEPTH), .SEL_W(SEL_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
        .lag_sel(cfg_lag), .tap_sel(cfg_pre),
        .newest(newest), .lagged(lagged), .tapped(tapped)
    );

    pmp_trigger #(.SAMPLE_W(SAMPLE_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .newest(newest), .lagged(lagged),
        .thr(cfg_thr), .idle(cap_idle), .over(over),
        .fire_now(fire_now), .disc_fire(disc_fire)
    );

    pmp_capture #(.SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W), .AW(AW),
                  .CHANNEL(CHANNEL), .DROP_W(DROP_W), .WORD_W(WORD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .fire_now(fire_now), .over(over),
        .tap(tapped), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .wr_base(wr_base), .free_words(free_words), .idle(cap_idle),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .commit_ptr(commit_ptr), .drop_count(drop_count)
    );

    pmp_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .AW(AW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .commit_ptr(commit_ptr),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_base(wr_base), .free_words(free_words)
    );

    // R8: a strobe always finds the capture window already open.
    assert_fire_opens_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disc_fire |-> !cap_idle);

    // R10: the drop counter only moves together with a strobe.
    assert_drop_needs_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> disc_fire);
endmodule

// File: tb/tb_pmp_discriminator.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_pmp_discriminator;
    localparam int SW    = 16;
    localparam int WW    = 2 * SW + 1;
    localparam int DEPTH = 16;
    localparam int CHAN  = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] sample_in, cfg_thr;
    logic [2:0]    cfg_lag, cfg_pre, cfg_post;
    logic          disc_fire, rd_en, rd_valid;
    logic [WW-1:0] rd_data;
    logic [15:0]   drop_count;

    int n_checks = 0, n_fail = 0, idx = 0, fire_seen = 0;
    int sbuf [0:4095];
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmp_discriminator #(.SAMPLE_W(SW), .HIST_DEPTH(8), .FIFO_DEPTH(DEPTH),
                        .CHANNEL(CHAN), .DROP_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .cfg_thr(cfg_thr),
        .cfg_lag(cfg_lag), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .disc_fire(disc_fire), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .drop_count(drop_count)
    );

    // Count strobe cycles just after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && disc_fire) fire_seen++;
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int s(input int i);
        return sbuf[i & 4095];
    endfunction

    // One clock: record the held sample under its index.
    task automatic cyc();
        idx++;
        sbuf[idx & 4095] = int'(sample_in);
        @(negedge clk);
    endtask

    task automatic step(input int v);
        sample_in = SW'(v);
        cyc();
    endtask

    task automatic hold(input int n);
        repeat (n) cyc();
    endtask

    task automatic pop();
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic config_set(input int lag, input int thr, input int pre, input int post);
        cfg_lag = 3'(lag); cfg_thr = SW'(thr); cfg_pre = 3'(pre); cfg_post = 3'(post);
    endtask

    // Build the expected event from the driven samples and read it out.
    task automatic expect_event(input int f, input int pre, input int post,
                                input int lag, input int thr, input string req);
        int wlen, peak, w;
        bit run;
        logic [WW-1:0] exp;
        wlen = pre + 1 + post;
        peak = 0;
        for (int k = f - pre; k <= f + post; k++) if (s(k) > peak) peak = s(k);
        w = 0; run = 1'b1;
        for (int j = 0; j <= post; j++) begin
            if (run && (s(f + j) - s(f + j - lag) > thr)) w++;
            else run = 1'b0;
        end
        exp = {1'b1, 4'(CHAN), 8'(f), 4'(w), 16'(peak)};
        chk(req, "event available", longint'(rd_valid), 1);
        chk("R6", "header word", longint'(rd_data), longint'(exp));
        pop();
        for (int k = 0; k < (wlen + 1) / 2; k++) begin
            int lo, hi;
            lo = s(f - pre + 2 * k);
            hi = (2 * k + 1 < wlen) ? s(f - pre + 2 * k + 1) : 0;
            exp = {1'b0, 16'(hi), 16'(lo)};
            chk("R5", "data word", longint'(rd_data), longint'(exp));
            pop();
        end
    endtask

    task automatic t_reset();
        chk("R1", "rd_valid after reset", longint'(rd_valid), 0);
        chk("R1", "disc_fire after reset", longint'(disc_fire), 0);
        chk("R1", "drop_count after reset", longint'(drop_count), 0);
    endtask

    task automatic t_basic();
        int f, f0;
        config_set(2, 100, 2, 3);
        f0 = fire_seen;
        step(50); hold(4);
        step(300); f = idx;
        chk("R2", "strobe not yet raised", longint'(disc_fire), 0);
        step(400);
        chk("R2", "strobe raised", longint'(disc_fire), 1);
        chk("R9", "nothing readable mid-window", longint'(rd_valid), 0);
        step(350);
        chk("R2", "strobe one cycle", longint'(disc_fire), 0);
        step(200); step(50); hold(6);
        chk("R2", "single strobe", longint'(fire_seen - f0), 1);
        expect_event(f, 2, 3, 2, 100, "R9");
        chk("R7", "fifo empty after one event", longint'(rd_valid), 0);
    endtask

    task automatic t_threshold_edge();
        int f, f0;
        config_set(1, 100, 0, 0);
        f0 = fire_seen;
        step(150); hold(4);
        chk("R2", "equal difference does not fire", longint'(fire_seen - f0), 0);
        chk("R2", "nothing stored on equal", longint'(rd_valid), 0);
        step(251); f = idx; hold(4);
        chk("R2", "difference above threshold fires", longint'(fire_seen - f0), 1);
        expect_event(f, 0, 0, 1, 100, "R2");
    endtask

    task automatic t_lag();
        int f, f0;
        config_set(1, 100, 0, 0);
        f0 = fire_seen;
        step(311); step(371); hold(4);
        chk("R4", "slow rise above threshold level is silent", longint'(fire_seen - f0), 0);
        step(251); hold(4);
        config_set(2, 100, 0, 0);
        hold(2);
        step(311); step(371); f = idx; hold(4);
        chk("R3", "same edge fires at lag 2", longint'(fire_seen - f0), 1);
        expect_event(f, 0, 0, 2, 100, "R3");
    endtask

    task automatic t_refire();
        int f, f0;
        config_set(1, 100, 0, 5);
        f0 = fire_seen;
        step(600); f = idx;
        step(900); hold(10);
        chk("R8", "second crossing in window blocked", longint'(fire_seen - f0), 1);
        expect_event(f, 0, 5, 1, 100, "R8");
        chk("R8", "only one event stored", longint'(rd_valid), 0);
    endtask

    task automatic t_odd_pack();
        int f;
        config_set(3, 50, 1, 1);
        hold(4);
        step(1000); f = idx;
        step(1100); hold(8);
        expect_event(f, 1, 1, 3, 50, "R5");
    endtask

    task automatic t_drop();
        int f1, f3, f0;
        config_set(1, 100, 7, 7);
        hold(8);
        f0 = fire_seen;
        step(1300); f1 = idx; hold(20);
        step(1500); hold(20);
        chk("R10", "drop counted", longint'(drop_count), 1);
        chk("R10", "strobe on dropped event", longint'(fire_seen - f0), 2);
        expect_event(f1, 7, 7, 1, 100, "R10");
        chk("R10", "dropped event left nothing", longint'(rd_valid), 0);
        step(1700); f3 = idx; hold(20);
        expect_event(f3, 7, 7, 1, 100, "R10");
        chk("R10", "drop count unchanged", longint'(drop_count), 1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) sbuf[i] = 0;
        rst_n = 1'b0; rd_en = 1'b0; sample_in = '0;
        config_set(1, 100, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idx = 0;
        t_reset();
        hold(3);
        t_reset();
        t_basic();
        t_threshold_edge();
        t_lag();
        t_refire();
        t_odd_pack();
        t_drop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL all-requirements watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule